// File: doc/BRIEF.md
# Auto-Detecting Dual-Style Host Register Interface

This block is the host-side front end of a serial bus controller. It lets one register file be driven by either of two common parallel processor buses. One style uses separate active-low write and read strobes. The other uses a single read/write direction line plus an open-drain transfer-acknowledge output. The block works out which style is attached from the first write strobe it sees after reset, and keeps that choice until the next reset.

The block holds four things: the control byte, the own-address byte, the clock-configuration byte and the interrupt vector. The control byte's three select bits, together with the address line `a0`, pick the register that a host access reaches. Data-register traffic and status reads go to the serial engine, which lies outside this block. They appear here as a status input, a read-buffer input and single-cycle strobes. During an interrupt-acknowledge cycle with interrupts enabled, the block places the vector on the data bus.

Mode FSM states: `MD_OPEN` (after reset; behaves as the strobe style), `MD_80LOCK` and `MD_68K`. Transitions:
- open→80lock: a write-strobe falling edge with chip select low.
- open→68k: a falling edge with chip select high.
- Both locked states are kept until reset.

Access FSM states: `AC_IDLE`, `AC_WR_STB`, `AC_WR_WAIT`, `AC_RD_STB`, `AC_RD_WAIT`, `AC_VEC`. Transitions:
- idle→vec: acknowledge input low with interrupt enable set. This takes priority.
- idle→wr_stb: a write request.
- idle→rd_stb: a read request.
- wr_stb→wr_wait and rd_stb→rd_wait: the access is still active.
- Any of the four access states→idle: the access has ended.
- vec→idle: the acknowledge input is released.

Top module: `hostbus_adapt`

## Requirements
- R1: After reset the interface uses the strobe style. `mode_68k`, `db_oe` and `dtack_oe` are 0, `ctrl_q` is 0x80 and the interrupt vector reads 0x00.
- R2: Only the first falling edge of `wr_n` after reset selects the bus style, and the choice holds until reset. If `cs_n` is high at that edge, the direction-line style is selected and `mode_68k` goes to 1. If `cs_n` is low, the strobe style is locked.
- R3: `dtack_oe` is only ever 1 in direction-line style. It is 1 from the cycle after an access starts until the cycle after `cs_n` (and `iack_n`) return high.
- R4: A write with `a0`=1 loads the control byte. The layout is bit7 PIN, bit6 ESO, bit5 ES1, bit4 ES2, bit3 ENI, bit2 STA, bit1 STO, bit0 ACK. The write raises `ctrl_wr_stb` for one cycle.
- R5: A read with `a0`=1 returns `stat_in` when ESO=1. When ESO=0 it returns `{stat_in[7:4], ctrl_q[3:0]}`.
- R6: With `a0`=0, the code {ESO,ES1,ES2} selects the register:
  - 100 is the data register. A write pulses `data_wr_stb` with `wr_data`. A read returns `rbuf_in` and pulses `data_rd_stb`.
  - 000 is the own address.
  - 010 is the clock configuration.
  - 001 is the vector.
  - Any other code reaches no register: writes are ignored and reads do not drive the bus.
- R7: The vector becomes 0x0F when direction-line style is selected. With `iack_n` low and ENI=1, the vector is driven on `db_out`. With ENI=0, `iack_n` is ignored.
- R8: `db_oe` is 1 only during a read of a selected register or during a vector cycle.
- R9: Each host access produces exactly one single-cycle strobe, however long the host holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Register select: 1 = control/status |
| wr_n | input | 1 | Write strobe (strobe style) or read/write line, 1 = read (direction-line style) |
| rd_n | input | 1 | Read strobe (strobe style only) |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| db_in | input | 8 | Host data in |
| db_out | output | 8 | Host data out |
| db_oe | output | 1 | Data bus driver enable |
| dtack_oe | output | 1 | Pull the open-drain acknowledge line low |
| mode_68k | output | 1 | Direction-line style selected |
| stat_in | input | 8 | Status byte from the serial engine |
| rbuf_in | input | 8 | Read buffer from the serial engine |
| ctrl_q | output | 8 | Control byte |
| own_addr_q | output | 8 | Own-address byte |
| clk_cfg_q | output | 8 | Clock-configuration byte |
| data_wr_stb | output | 1 | Data register write strobe |
| wr_data | output | 8 | Data accompanying `data_wr_stb` |
| data_rd_stb | output | 1 | Data register read strobe |
| ctrl_wr_stb | output | 1 | Control byte write strobe |

## Verification
A wrong mode state first shows when the bus style is locked. `mode_68k` would be wrong one cycle after the deciding edge, and the vector would read back as the wrong default. `dtack_oe` would also appear or fail to appear on the next access. A wrong access state shows within one or two cycles of the access starting: a strobe repeats or goes missing, `db_oe` is raised for an unselected code, or `dtack_oe` stays asserted after chip select has risen. A select decode error shows as the wrong byte on `db_out` in the same read.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
    typedef enum logic [1:0] {MD_OPEN, MD_80LOCK, MD_68K} bus_mode_e;
    typedef enum logic [2:0] {
        AC_IDLE, AC_WR_STB, AC_WR_WAIT, AC_RD_STB, AC_RD_WAIT, AC_VEC
    } acc_state_e;
    typedef enum logic [2:0] {RS_CTRL, RS_DATA, RS_OWN, RS_CLK, RS_VEC, RS_NONE} reg_sel_e;
    localparam int CB_ESO = 6;
    localparam int CB_ES1 = 5;
    localparam int CB_ES2 = 4;
    localparam int CB_ENI = 3;
    localparam int TEST_BITS = 4;
endpackage

// File: rtl/hostbus_mode_det.sv
module hostbus_mode_det
    import hostbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      wr_n,
    output logic      is68k,
    output logic      lock_68k
);
    bus_mode_e mode, mode_nx;
    logic      wr_prev;
    logic      wr_fall;

    assign wr_fall = wr_prev && !wr_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MD_OPEN;
            wr_prev <= 1'b1;
        end else begin
            mode    <= mode_nx;
            wr_prev <= wr_n;
        end
    end

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MD_OPEN: begin
                if (wr_fall && cs_n)       mode_nx = MD_68K;
                else if (wr_fall && !cs_n) mode_nx = MD_80LOCK;
            end
            MD_80LOCK: mode_nx = MD_80LOCK;
            MD_68K:    mode_nx = MD_68K;
            default:   mode_nx = MD_OPEN;
        endcase
    end

    always_comb begin
        is68k    = (mode == MD_68K);
        lock_68k = (mode == MD_OPEN) && wr_fall && cs_n;
    end
endmodule

// File: rtl/hostbus_access_fsm.sv
module hostbus_access_fsm
    import hostbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is68k,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic iack_n,
    input  logic eni,
    output logic wr_stb,
    output logic rd_stb,
    output logic rd_phase,
    output logic vec_phase,
    output logic dtack_oe
);
    acc_state_e state, state_nx;
    logic wr_req, rd_req, cyc_any, vec_req;

    assign wr_req  = !cs_n && !wr_n;
    assign rd_req  = is68k ? (!cs_n && wr_n) : (!cs_n && !rd_n);
    assign cyc_any = is68k ? !cs_n : (!cs_n && (!wr_n || !rd_n));
    assign vec_req = !iack_n && eni;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= AC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            AC_IDLE: begin
                if (vec_req)     state_nx = AC_VEC;
                else if (wr_req) state_nx = AC_WR_STB;
                else if (rd_req) state_nx = AC_RD_STB;
            end
            AC_WR_STB:  state_nx = cyc_any ? AC_WR_WAIT : AC_IDLE;
            AC_WR_WAIT: state_nx = cyc_any ? AC_WR_WAIT : AC_IDLE;
            AC_RD_STB:  state_nx = cyc_any ? AC_RD_WAIT : AC_IDLE;
            AC_RD_WAIT: state_nx = cyc_any ? AC_RD_WAIT : AC_IDLE;
            AC_VEC:     state_nx = !iack_n ? AC_VEC : AC_IDLE;
            default:    state_nx = AC_IDLE;
        endcase
    end

    always_comb begin
        wr_stb    = (state == AC_WR_STB);
        rd_stb    = (state == AC_RD_STB);
        rd_phase  = (state == AC_RD_STB) || (state == AC_RD_WAIT);
        vec_phase = (state == AC_VEC);
        dtack_oe  = is68k && (state != AC_IDLE);
    end
endmodule

// File: rtl/hostbus_regs.sv
module hostbus_regs
    import hostbus_pkg::*;
#(
    parameter int          DW      = 8,
    parameter logic [DW-1:0] VEC_80  = 8'h00,
    parameter logic [DW-1:0] VEC_68K = 8'h0F,
    parameter logic [DW-1:0] CTRL_RST = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a0,
    input  logic [DW-1:0] db_in,
    input  logic [DW-1:0] stat_in,
    input  logic [DW-1:0] rbuf_in,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic          rd_phase,
    input  logic          vec_phase,
    input  logic          lock_68k,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] own_addr_q,
    output logic [DW-1:0] clk_cfg_q,
    output logic [DW-1:0] wr_data,
    output logic          data_wr_stb,
    output logic          data_rd_stb,
    output logic          ctrl_wr_stb,
    output logic          eni
);
    reg_sel_e      sel;
    logic [DW-1:0] vec_q;
    logic [DW-1:0] rdata;

    always_comb begin
        if (a0) sel = RS_CTRL;
        else begin
            unique case ({ctrl_q[CB_ESO], ctrl_q[CB_ES1], ctrl_q[CB_ES2]})
                3'b100:  sel = RS_DATA;
                3'b000:  sel = RS_OWN;
                3'b010:  sel = RS_CLK;
                3'b001:  sel = RS_VEC;
                default: sel = RS_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= CTRL_RST;
            own_addr_q <= '0;
            clk_cfg_q  <= '0;
            vec_q      <= VEC_80;
        end else begin
            if (wr_stb) begin
                unique case (sel)
                    RS_CTRL: ctrl_q     <= db_in;
                    RS_OWN:  own_addr_q <= db_in;
                    RS_CLK:  clk_cfg_q  <= db_in;
                    RS_VEC:  vec_q      <= db_in;
                    default: ;
                endcase
            end
            if (lock_68k) vec_q <= VEC_68K;
        end
    end

    always_comb begin
        unique case (sel)
            RS_CTRL: rdata = ctrl_q[CB_ESO] ? stat_in
                           : {stat_in[DW-1:TEST_BITS], ctrl_q[TEST_BITS-1:0]};
            RS_DATA: rdata = rbuf_in;
            RS_OWN:  rdata = own_addr_q;
            RS_CLK:  rdata = clk_cfg_q;
            RS_VEC:  rdata = vec_q;
            default: rdata = '0;
        endcase
    end

    always_comb begin
        db_oe       = vec_phase || (rd_phase && (sel != RS_NONE));
        db_out      = vec_phase ? vec_q : (db_oe ? rdata : '0);
        ctrl_wr_stb = wr_stb && (sel == RS_CTRL);
        data_wr_stb = wr_stb && (sel == RS_DATA);
        data_rd_stb = rd_stb && (sel == RS_DATA);
        wr_data     = db_in;
        eni         = ctrl_q[CB_ENI];
    end
endmodule

// File: rtl/hostbus_adapt.sv
module hostbus_adapt
    import hostbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          a0,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          iack_n,
    input  logic [DW-1:0] db_in,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    output logic          dtack_oe,
    output logic          mode_68k,
    input  logic [DW-1:0] stat_in,
    input  logic [DW-1:0] rbuf_in,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] own_addr_q,
    output logic [DW-1:0] clk_cfg_q,
    output logic          data_wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          data_rd_stb,
    output logic          ctrl_wr_stb
);
    logic lock_68k, eni, wr_stb, rd_stb, rd_phase, vec_phase;

    hostbus_mode_det u_mode (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .is68k(mode_68k), .lock_68k(lock_68k)
    );

    hostbus_access_fsm u_acc (
        .clk(clk), .rst_n(rst_n), .is68k(mode_68k), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .iack_n(iack_n), .eni(eni), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .rd_phase(rd_phase), .vec_phase(vec_phase), .dtack_oe(dtack_oe)
    );

    hostbus_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .a0(a0), .db_in(db_in), .stat_in(stat_in),
        .rbuf_in(rbuf_in), .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_phase(rd_phase),
        .vec_phase(vec_phase), .lock_68k(lock_68k), .db_out(db_out), .db_oe(db_oe),
        .ctrl_q(ctrl_q), .own_addr_q(own_addr_q), .clk_cfg_q(clk_cfg_q),
        .wr_data(wr_data), .data_wr_stb(data_wr_stb), .data_rd_stb(data_rd_stb),
        .ctrl_wr_stb(ctrl_wr_stb), .eni(eni)
    );
endmodule

// File: rtl/hostbus_adapt_chk.sv
module hostbus_adapt_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic iack_n,
    input logic db_oe,
    input logic dtack_oe,
    input logic mode_68k,
    input logic data_wr_stb,
    input logic data_rd_stb,
    input logic ctrl_wr_stb
);
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_68k |=> mode_68k); // R2
    AST_DTACK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_oe |-> mode_68k); // R3
    AST_DTACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && iack_n) |=> !dtack_oe); // R3
    AST_OE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> ($past(!cs_n) || $past(!iack_n))); // R8
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_wr_stb, data_rd_stb, ctrl_wr_stb})); // R9
    AST_DWR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_stb |=> !data_wr_stb); // R9
    AST_CWR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_stb |=> !ctrl_wr_stb); // R4
endmodule

bind hostbus_adapt hostbus_adapt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .iack_n(iack_n), .db_oe(db_oe),
    .dtack_oe(dtack_oe), .mode_68k(mode_68k), .data_wr_stb(data_wr_stb),
    .data_rd_stb(data_rd_stb), .ctrl_wr_stb(ctrl_wr_stb)
);

// File: tb/hostbus_adapt_bench.sv
module hostbus_adapt_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, a0 = 1'b0, wr_n = 1'b1, rd_n = 1'b1, iack_n = 1'b1;
    logic [7:0] db_in = 8'h00;
    logic [7:0] stat_in = 8'h5C, rbuf_in = 8'h3E;
    logic [7:0] db_out, ctrl_q, own_addr_q, clk_cfg_q, wr_data;
    logic db_oe, dtack_oe, mode_68k, data_wr_stb, data_rd_stb, ctrl_wr_stb;

    int errors = 0, checks = 0;
    int n_dwr = 0, n_drd = 0, n_cwr = 0;
    logic [7:0] last_wd = 8'h00;
    bit done = 0;

    always #2 clk = ~clk;

    hostbus_adapt u_hostbus_adapt (.*);

    always @(negedge clk) begin
        if (data_wr_stb) begin n_dwr++; last_wd = wr_data; end
        if (data_rd_stb) n_drd++;
        if (ctrl_wr_stb) n_cwr++;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr80(logic a, logic [7:0] d, int hold);
        @(negedge clk);
        a0 = a; db_in = d; cs_n = 1'b0; wr_n = 1'b0;
        idle(hold);
        cs_n = 1'b1; wr_n = 1'b1;
        idle(4);
    endtask

    task automatic rd80(logic a, logic [7:0] exp, logic exp_oe, string req);
        @(negedge clk);
        a0 = a; cs_n = 1'b0; rd_n = 1'b0;
        idle(2);
        chk(req, db_oe, exp_oe);
        if (exp_oe) chk(req, db_out, exp);
        cs_n = 1'b1; rd_n = 1'b1;
        idle(4);
    endtask

    // {write, a0, data, expected, expected_oe}
    localparam int NT = 21;
    localparam logic [18:0] TBL [NT] = '{
        {1'b1, 1'b1, 8'h10, 8'h00, 1'b0},  // select vector (R4)
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b1},  // vector reset value R1
        {1'b1, 1'b1, 8'h00, 8'h00, 1'b0},
        {1'b1, 1'b0, 8'h2A, 8'h00, 1'b0},  // own address R6
        {1'b0, 1'b0, 8'h00, 8'h2A, 1'b1},
        {1'b1, 1'b1, 8'h20, 8'h00, 1'b0},
        {1'b1, 1'b0, 8'h1C, 8'h00, 1'b0},  // clock config
        {1'b0, 1'b0, 8'h00, 8'h1C, 1'b1},
        {1'b1, 1'b1, 8'h10, 8'h00, 1'b0},
        {1'b1, 1'b0, 8'hA5, 8'h00, 1'b0},  // vector
        {1'b0, 1'b0, 8'h00, 8'hA5, 1'b1},
        {1'b1, 1'b1, 8'h0B, 8'h00, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h5B, 1'b1},  // ESO=0 test read R5
        {1'b1, 1'b1, 8'hC0, 8'h00, 1'b0},
        {1'b0, 1'b1, 8'h00, 8'h5C, 1'b1},  // ESO=1 status R5
        {1'b0, 1'b0, 8'h00, 8'h3E, 1'b1},  // data read buffer
        {1'b1, 1'b1, 8'h70, 8'h00, 1'b0},
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b0},  // unselected code: no drive R8
        {1'b1, 1'b0, 8'h77, 8'h00, 1'b0},  // ignored write
        {1'b1, 1'b1, 8'h00, 8'h00, 1'b0},
        {1'b0, 1'b0, 8'h00, 8'h2A, 1'b1}   // own address unchanged
    };

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 mode", mode_68k, 0);
        chk("R1 oe", db_oe, 0);
        chk("R1 dtack", dtack_oe, 0);
        chk("R1 ctrl", ctrl_q, 8'h80);

        for (int i = 0; i < NT; i++) begin
            if (TBL[i][18]) wr80(TBL[i][17], TBL[i][16:9], 3);
            else rd80(TBL[i][17], TBL[i][8:1], TBL[i][0], "R5_R6 table");
        end
        chk("R4 ctrl value", ctrl_q, 8'h00);
        chk("R2 strobe-style lock", mode_68k, 0);

        begin
            int c0, d0;
            c0 = n_cwr;
            wr80(1'b1, 8'hC0, 12);
            chk("R4 one ctrl strobe", n_cwr - c0, 1);
            d0 = n_dwr;
            wr80(1'b0, 8'h99, 15);
            chk("R9 one data strobe", n_dwr - d0, 1);
            chk("R6 wr_data", last_wd, 8'h99);
            d0 = n_drd;
            rd80(1'b0, 8'h3E, 1'b1, "R6 data read");
            chk("R6 one read strobe", n_drd - d0, 1);
        end

        @(negedge clk); iack_n = 1'b0;
        idle(2);
        chk("R7 iack ignored ENI=0", db_oe, 0);
        iack_n = 1'b1; idle(3);
        wr80(1'b1, 8'h08, 3);
        @(negedge clk); iack_n = 1'b0;
        idle(2);
        chk("R7 vector oe", db_oe, 1);
        chk("R7 vector value", db_out, 8'hA5);
        chk("R3 no dtack strobe style", dtack_oe, 0);
        iack_n = 1'b1; idle(3);

        @(negedge clk); wr_n = 1'b0;
        idle(2);
        chk("R2 later edge ignored", mode_68k, 0);
        chk("R3 dtack stays off", dtack_oe, 0);
        wr_n = 1'b1; idle(3);

        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(2);
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk);
        chk("R2 direction style lock", mode_68k, 1);
        a0 = 1'b1; db_in = 8'h08; cs_n = 1'b0;
        idle(2);
        chk("R3 dtack on write", dtack_oe, 1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R3 dtack released", dtack_oe, 0);
        wr_n = 1'b1; idle(3);
        chk("R4 ctrl via direction style", ctrl_q, 8'h08);

        @(negedge clk); iack_n = 1'b0;
        idle(2);
        chk("R7 default vector 0x0F", db_out, 8'h0F);
        chk("R7 vector oe", db_oe, 1);
        chk("R3 dtack on vector", dtack_oe, 1);
        iack_n = 1'b1;
        @(negedge clk);
        chk("R3 dtack off after iack", dtack_oe, 0);
        idle(3);

        @(negedge clk); a0 = 1'b1; cs_n = 1'b0;
        idle(2);
        chk("R5 test read direction style", db_out, 8'h58);
        chk("R8 oe on read", db_oe, 1);
        cs_n = 1'b1; idle(3);
        chk("R2 stays locked", mode_68k, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule